// File: doc/BRIEF.md
# Multi-mode interval counter channel

This block is a single down-counting channel of an interval timer. It counts falling edges of a slow counting clock that is sampled in the system clock domain. It also watches a gate input, and it drives one output pin whose waveform depends on a 3-bit operating mode. Software-side logic programs the channel with two plain one-cycle strobes. The first selects the mode, which clears the stored preset and the count. The second stores a 16-bit preset. The current count is visible on a port at all times.

The six modes are:

- code 0: terminal-count signalling
- code 1: retriggerable one-shot started by the gate
- code 2: periodic rate generator
- code 3: square wave
- code 4: strobe started by writing the preset
- code 5: strobe started by the gate

Mode codes 6 and 7 select modes 2 and 3. Both control strobes and the gate are level/pulse controls without handshake, so no back-pressure applies. A new preset does not change the count on the spot. It is copied into the count on the next falling edge of the counting clock.

Top module: `ict_channel`

## Requirements
- R1: After reset the count reads 0, the output is high and the channel is in mode 0 with a zero preset.
- R2: A mode strobe clears the stored preset and the count to 0. It sets the output low for mode 0 and high for every other mode. Codes 6 and 7 behave exactly as codes 2 and 3.
- R3: The count changes only on a falling edge of the counting clock. A pending load copies the reload value into the count on the first such edge. A preset write makes a load pending in modes 0, 2, 3 and 4. A gate rising edge makes a load pending in modes 1, 2, 3 and 5. In every other case the count steps down with 16-bit wrap-around.
- R4: In modes 0, 2, 3 and 4 a low gate holds the count. In modes 1 and 5 the gate level has no effect on counting.
- R5: In mode 0 the output is low from a preset write until the count reaches 0, then it goes high.
- R6: In mode 1 the output goes low when a trigger load happens and goes high when the count reaches 0. A new gate rising edge reloads the preset; without a trigger the preset is never loaded.
- R7: In mode 2 the output is low exactly while the count is 1. On the next edge the count reloads the preset and the output returns high. A zero preset counts from 0 to 0xFFFF.
- R8: In mode 3 the count steps by 2 and stays even. An even preset N loads N, an odd preset N loads N-1, and a zero preset loads 0xFFFE. The output starts high at a load and toggles at each reload. With period N counting-clock edges, the output is high for (N+1)/2 edges (integer division) and low for the rest.
- R9: In modes 2 and 3 a preset write of value 1 is ignored: the stored preset and the count are unchanged.
- R10: In modes 4 and 5, once the channel has loaded, the output is low exactly while the count is 0 and high otherwise.
- R11: In modes 0 and 4 a rising edge of the gate does not reload the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_clk | input | 1 | Counting clock, sampled; falling edges advance the count |
| gate | input | 1 | Gate: level enables counting, rising edge triggers a load |
| mode_wr | input | 1 | One-cycle strobe that programs the mode |
| mode_in | input | 3 | Mode code taken on mode_wr |
| preset_wr | input | 1 | One-cycle strobe that writes the preset |
| preset_in | input | CNT_W | Preset value taken on preset_wr |
| count_o | output | CNT_W | Live count |
| out_o | output | 1 | Channel output pin |

## Verification
The checker watches several properties on every cycle. The count moves only on a counting-clock falling edge or a mode strobe. A mode strobe always leaves a zero count and the right output level. In the rate generator, a low output always coincides with a count of 1. The square-wave count never becomes odd. In the strobe modes, a low output only appears at count 0. Other behaviour needs the bench's scenarios. These cover the duty cycle of the square wave for every preset from 2 to 9, and the rate-generator period for presets 2 to 8. They also cover one-shot retriggering, suspension by the gate, rejection of a preset of 1, and the wrap of a zero preset.

// File: rtl/ict_pkg.sv
package ict_pkg;

  typedef enum logic [2:0] {
    MD_TC_IRQ    = 3'd0,
    MD_ONESHOT   = 3'd1,
    MD_RATE      = 3'd2,
    MD_SQUARE    = 3'd3,
    MD_SW_STROBE = 3'd4,
    MD_HW_STROBE = 3'd5
  } ict_mode_e;

  // codes 6 and 7 fold onto 2 and 3
  function automatic ict_mode_e norm_mode(input logic [2:0] code);
    if (code[2] && code[1]) return ict_mode_e'({1'b0, code[1:0]});
    return ict_mode_e'(code);
  endfunction

  // modes whose counting is suspended by a low gate
  function automatic logic level_gated(input ict_mode_e m);
    return (m == MD_TC_IRQ) || (m == MD_RATE) || (m == MD_SQUARE) || (m == MD_SW_STROBE);
  endfunction

  // modes in which a gate rising edge requests a load
  function automatic logic edge_triggered(input ict_mode_e m);
    return (m == MD_ONESHOT) || (m == MD_RATE) || (m == MD_SQUARE) || (m == MD_HW_STROBE);
  endfunction

  // modes in which a preset write requests a load
  function automatic logic write_loads(input ict_mode_e m);
    return level_gated(m);
  endfunction

  // a preset of one cannot produce a period in the periodic modes
  function automatic logic preset_refused(input ict_mode_e m, input logic is_one);
    return is_one && ((m == MD_RATE) || (m == MD_SQUARE));
  endfunction

endpackage

// File: rtl/ict_sync.sv
module ict_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
    end else begin
      pipe[0] <= d_i;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/ict_reload_calc.sv
module ict_reload_calc
  import ict_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  ict_mode_e        mode_i,
  input  logic [CNT_W-1:0] preset_i,
  output logic [CNT_W-1:0] load_o,
  output logic             odd_o
);
  localparam logic [CNT_W-1:0] SQ_ZERO_LOAD = {{(CNT_W-1){1'b1}}, 1'b0};

  always_comb begin
    odd_o = preset_i[0];
    if (mode_i == MD_SQUARE) begin
      if (preset_i == '0) load_o = SQ_ZERO_LOAD;
      else                load_o = {preset_i[CNT_W-1:1], 1'b0};
    end else begin
      load_o = preset_i;
    end
  end
endmodule

// File: rtl/ict_count_core.sv
module ict_count_core
  import ict_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             gate_lvl_i,
  input  logic             gate_rise_i,
  input  logic             mode_wr_i,
  input  logic [2:0]       mode_code_i,
  input  logic             preset_wr_i,
  input  logic [CNT_W-1:0] preset_val_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             load_odd_i,
  output ict_mode_e        mode_o,
  output logic [CNT_W-1:0] preset_o,
  output logic [CNT_W-1:0] count_o,
  output logic             out_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  ict_mode_e        mode_q;
  logic [CNT_W-1:0] preset_q, count_q;
  logic             out_q, pend_q, run_q, stretch_q;
  logic             enabled, refused;
  ict_mode_e        new_mode;

  assign new_mode = norm_mode(mode_code_i);
  assign enabled  = level_gated(mode_q) ? gate_lvl_i : 1'b1;
  assign refused  = preset_refused(mode_q, preset_val_i == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MD_TC_IRQ;
      preset_q  <= '0;
      count_q   <= '0;
      out_q     <= 1'b1;
      pend_q    <= 1'b0;
      run_q     <= 1'b0;
      stretch_q <= 1'b0;
    end else if (mode_wr_i) begin
      mode_q    <= new_mode;
      preset_q  <= '0;
      count_q   <= '0;
      out_q     <= (new_mode != MD_TC_IRQ);
      pend_q    <= 1'b0;
      run_q     <= 1'b0;
      stretch_q <= 1'b0;
    end else begin
      if (tick_i) begin
        if (pend_q) begin
          count_q <= load_val_i;
          pend_q  <= 1'b0;
          run_q   <= 1'b1;
          unique case (mode_q)
            MD_ONESHOT: out_q <= 1'b0;
            MD_SQUARE: begin
              out_q     <= 1'b1;
              stretch_q <= load_odd_i;
            end
            MD_RATE, MD_SW_STROBE, MD_HW_STROBE: out_q <= 1'b1;
            default: ;
          endcase
        end else if (run_q && enabled) begin
          unique case (mode_q)
            MD_TC_IRQ, MD_ONESHOT: begin
              count_q <= count_q - ONE;
              if (count_q == ONE) out_q <= 1'b1;
            end
            MD_RATE: begin
              if (count_q == ONE) begin
                count_q <= load_val_i;
                out_q   <= 1'b1;
              end else begin
                count_q <= count_q - ONE;
                out_q   <= (count_q != TWO);
              end
            end
            MD_SQUARE: begin
              if (count_q == TWO && stretch_q) begin
                count_q   <= '0;
                stretch_q <= 1'b0;
              end else if (count_q == TWO || count_q == '0) begin
                count_q   <= load_val_i;
                out_q     <= ~out_q;
                stretch_q <= ~out_q & load_odd_i;
              end else begin
                count_q <= count_q - TWO;
              end
            end
            default: begin
              count_q <= count_q - ONE;
              out_q   <= (count_q != ONE);
            end
          endcase
        end
      end
      // writes and triggers come last so they override a same-cycle tick
      if (preset_wr_i && !refused) begin
        preset_q <= preset_val_i;
        if (write_loads(mode_q)) pend_q <= 1'b1;
        if (mode_q == MD_TC_IRQ) out_q <= 1'b0;
      end
      if (gate_rise_i && edge_triggered(mode_q)) pend_q <= 1'b1;
    end
  end

  assign mode_o   = mode_q;
  assign preset_o = preset_q;
  assign count_o  = count_q;
  assign out_o    = out_q;
endmodule

// File: rtl/ict_channel.sv
module ict_channel
  import ict_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_clk,
  input  logic             gate,
  input  logic             mode_wr,
  input  logic [2:0]       mode_in,
  input  logic             preset_wr,
  input  logic [CNT_W-1:0] preset_in,
  output logic [CNT_W-1:0] count_o,
  output logic             out_o
);
  localparam int NSIG   = 2;
  localparam int IDX_CK = 0;
  localparam int IDX_GT = 1;

  logic [NSIG-1:0]  raw_in, synced, synced_d;
  logic             cclk_fall, gate_rise, gate_lvl;
  ict_mode_e        mode_q;
  logic [CNT_W-1:0] preset_q, load_val;
  logic             load_odd;

  assign raw_in = {gate, cnt_clk};

  ict_sync #(.N(NSIG), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_in),
    .q_o   (synced)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) synced_d <= '0;
    else        synced_d <= synced;
  end

  assign cclk_fall = synced_d[IDX_CK] & ~synced[IDX_CK];
  assign gate_rise = synced[IDX_GT] & ~synced_d[IDX_GT];
  assign gate_lvl  = synced[IDX_GT];

  ict_reload_calc #(.CNT_W(CNT_W)) u_reload (
    .mode_i   (mode_q),
    .preset_i (preset_q),
    .load_o   (load_val),
    .odd_o    (load_odd)
  );

  ict_count_core #(.CNT_W(CNT_W)) u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (cclk_fall),
    .gate_lvl_i   (gate_lvl),
    .gate_rise_i  (gate_rise),
    .mode_wr_i    (mode_wr),
    .mode_code_i  (mode_in),
    .preset_wr_i  (preset_wr),
    .preset_val_i (preset_in),
    .load_val_i   (load_val),
    .load_odd_i   (load_odd),
    .mode_o       (mode_q),
    .preset_o     (preset_q),
    .count_o      (count_o),
    .out_o        (out_o)
  );
endmodule

// File: rtl/ict_channel_chk.sv
module ict_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_wr,
  input logic [2:0]       mode_in,
  input logic             tick,
  input logic [2:0]       mode_q,
  input logic [CNT_W-1:0] count_o,
  input logic             out_o
);
  AST_PROGRAM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (count_o == '0)); // R2

  AST_PROGRAM_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (out_o == ($past(mode_in) != 3'd0))); // R2

  AST_COUNT_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !mode_wr) |=> $stable(count_o)); // R3

  AST_RATE_LOW_AT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == 3'd2) && !out_o) |-> (count_o == CNT_W'(1))); // R7

  AST_SQUARE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd3) |-> !count_o[0]); // R8

  AST_STROBE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (((mode_q == 3'd4) || (mode_q == 3'd5)) && !out_o) |-> (count_o == '0)); // R10
endmodule

bind ict_channel ict_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mode_wr (mode_wr),
  .mode_in (mode_in),
  .tick    (cclk_fall),
  .mode_q  (mode_q),
  .count_o (count_o),
  .out_o   (out_o)
);

// File: tb/tb_ict_channel.sv
`timescale 1ns/1ps
module tb_ict_channel;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cnt_clk = 1'b0;
  logic         gate = 1'b0;
  logic         mode_wr = 1'b0;
  logic [2:0]   mode_in = 3'd0;
  logic         preset_wr = 1'b0;
  logic [W-1:0] preset_in = '0;
  logic [W-1:0] count_o;
  logic         out_o;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  ict_channel #(.CNT_W(W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .cnt_clk(cnt_clk), .gate(gate),
    .mode_wr(mode_wr), .mode_in(mode_in), .preset_wr(preset_wr),
    .preset_in(preset_in), .count_o(count_o), .out_o(out_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    cnt_clk = 1'b1; cyc(4);
    cnt_clk = 1'b0; cyc(6);
  endtask

  task automatic set_gate(input logic v);
    gate = v; cyc(6);
  endtask

  task automatic prog(input logic [2:0] m);
    @(negedge clk); mode_in = m; mode_wr = 1'b1;
    @(negedge clk); mode_wr = 1'b0;
    cyc(2);
  endtask

  task automatic pre(input logic [W-1:0] v);
    @(negedge clk); preset_in = v; preset_wr = 1'b1;
    @(negedge clk); preset_wr = 1'b0;
    cyc(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(5); rst_n = 1'b1; cyc(2);
    chk("R1 count", count_o, 0);
    chk("R1 out", out_o, 1);

    // mode 0
    set_gate(1'b1);
    prog(3'd0);
    chk("R2 mode0 out", out_o, 0);
    chk("R2 mode0 count", count_o, 0);
    pre(16'd5);
    tick(); chk("R3 load", count_o, 5); chk("R5 low", out_o, 0);
    for (int k = 4; k >= 1; k--) begin
      tick(); chk("R5 count", count_o, k); chk("R5 low", out_o, 0);
    end
    tick(); chk("R5 tc count", count_o, 0); chk("R5 tc high", out_o, 1);
    tick(); chk("R3 wrap", count_o, 16'hFFFF);
    set_gate(1'b0); tick(); tick();
    chk("R4 mode0 hold", count_o, 16'hFFFF);
    set_gate(1'b1);
    chk("R11 mode0 rise", count_o, 16'hFFFF);
    tick(); chk("R11 mode0 no reload", count_o, 16'hFFFE);

    // mode 4
    prog(3'd4); chk("R2 mode4 out", out_o, 1);
    pre(16'd3); tick(); chk("R3 mode4 load", count_o, 3);
    set_gate(1'b0); set_gate(1'b1);
    chk("R11 mode4 rise", count_o, 3);
    tick(); chk("R10 m4 2", count_o, 2); chk("R10 m4 out2", out_o, 1);
    tick(); chk("R10 m4 1", count_o, 1); chk("R10 m4 out1", out_o, 1);
    tick(); chk("R10 m4 0", count_o, 0); chk("R10 m4 strobe", out_o, 0);
    tick(); chk("R10 m4 after", count_o, 16'hFFFF); chk("R10 m4 high", out_o, 1);

    // mode 5
    set_gate(1'b0);
    prog(3'd5); pre(16'd2); tick();
    chk("R3 mode5 waits", count_o, 0);
    set_gate(1'b1); tick();
    chk("R3 mode5 trig load", count_o, 2); chk("R10 m5 out", out_o, 1);
    tick(); chk("R10 m5 1", count_o, 1);
    tick(); chk("R10 m5 0", count_o, 0); chk("R10 m5 strobe", out_o, 0);
    tick(); chk("R10 m5 after", count_o, 16'hFFFF); chk("R10 m5 high", out_o, 1);
    set_gate(1'b0); tick();
    chk("R4 mode5 ignores level", count_o, 16'hFFFE);

    // mode 1
    prog(3'd1); chk("R2 mode1 out", out_o, 1);
    pre(16'd3); tick(); chk("R6 no trigger", count_o, 0);
    set_gate(1'b1); tick();
    chk("R6 trig load", count_o, 3); chk("R6 low", out_o, 0);
    set_gate(1'b0); tick(); chk("R4 mode1 ignores level", count_o, 2);
    set_gate(1'b1); tick();
    chk("R6 retrigger", count_o, 3); chk("R6 still low", out_o, 0);
    tick(); tick(); chk("R6 at 1", count_o, 1); chk("R6 low at 1", out_o, 0);
    tick(); chk("R6 at 0", count_o, 0); chk("R6 high", out_o, 1);

    // mode 2 period sweep
    for (int n = 2; n <= 8; n++) begin
      prog(3'd2); pre(W'(n)); tick();
      chk("R7 load", count_o, n); chk("R7 load out", out_o, 1);
      for (int p = 0; p < 2; p++) begin
        for (int k = n - 1; k >= 1; k--) begin
          tick(); chk("R7 count", count_o, k); chk("R7 out", out_o, (k != 1));
        end
        tick(); chk("R7 reload", count_o, n); chk("R7 reload out", out_o, 1);
      end
    end

    // preset of one refused in mode 2
    prog(3'd2); pre(16'd4); tick();
    pre(16'd1);
    chk("R9 no load", count_o, 4);
    tick(); tick(); tick(); chk("R9 at 1", count_o, 1);
    tick(); chk("R9 kept preset", count_o, 4);

    // preset cleared by programming, zero preset wraps
    prog(3'd2);
    set_gate(1'b0); set_gate(1'b1); tick();
    chk("R2 preset cleared", count_o, 0);
    tick(); chk("R7 zero wraps", count_o, 16'hFFFF); chk("R7 zero out", out_o, 1);

    // alias code 6 acts as mode 2
    prog(3'd6); chk("R2 alias out", out_o, 1);
    pre(16'd3); tick(); chk("R2 alias load", count_o, 3);
    tick(); tick(); chk("R2 alias low", out_o, 0);
    tick(); chk("R2 alias reload", count_o, 3); chk("R2 alias high", out_o, 1);

    // mode 3 duty sweep
    for (int n = 2; n <= 9; n++) begin
      prog(3'd3); pre(W'(n));
      for (int t = 0; t < 2 * n; t++) begin
        tick();
        if (t == 0) chk("R8 load", count_o, n & ~1);
        chk("R8 duty", out_o, ((t % n) < ((n + 1) / 2)));
        chk("R8 even", count_o[0], 0);
      end
    end

    prog(3'd3); pre(16'd0); tick();
    chk("R8 zero load", count_o, 16'hFFFE);
    tick(); chk("R8 step two", count_o, 16'hFFFC);

    prog(3'd3); pre(16'd1); tick();
    chk("R9 square refuse", count_o, 0);

    prog(3'd3); pre(16'd8); tick();
    set_gate(1'b0); tick(); tick();
    chk("R4 mode3 hold", count_o, 8);
    set_gate(1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule